// File: doc/BRIEF.md
# Decoder Status and Auxiliary-Data Register Bank

This block collects status from a frame-based digital sound decoder and holds it in registers that a host polls. It publishes three kinds of information. The first is an error tally over a fixed window of 128 frames, which stands for a 128 ms period at one frame per millisecond. The second is a sticky configuration-change flag that can only rise on a 16-frame boundary. The third is an 11-bit auxiliary word that is captured on every frame strobe.

The auxiliary word has two flags. A freshness flag says an unread word is waiting. A loss flag says a word was replaced before the host read it. A read of the upper auxiliary byte clears both flags. A read of the status byte clears the configuration-change flag. Frame demodulation and the serial host bus sit outside this block. The block sees only single-cycle strobes and pulses on one clock.

Top module: `dec_status_regs`

## Requirements
- R1: The frame window closes on every 128th frame strobe. The cycle after the closing strobe, `err_cnt_o` shows the number of cycles with `err_flag_i` high since the previous window closed. A pulse in the same cycle as the closing strobe counts toward the window that is closing.
- R2: `err_cnt_o` changes only in the cycle after a closing frame strobe and holds its value at all other times.
- R3: The window tally saturates at 255 and does not wrap.
- R4: On each frame strobe, `aux_bits_i` is captured. From the next cycle, `aux_hi_o` holds bits 10..3 and `aux_lo_o` holds bits 2..0. Both hold their values until the next frame strobe.
- R5: A frame strobe sets `aux_new_o`. A `rd_aux1_i` read with no frame strobe in the same cycle clears it. When a strobe and the read fall in the same cycle, the strobe wins and `aux_new_o` stays set.
- R6: `aux_ovw_o` is set when a frame strobe arrives while an unread word is pending (`aux_new_o` or `aux_ovw_o` set) and `rd_aux1_i` is low in that cycle. A strobe that coincides with `rd_aux1_i` leaves `aux_ovw_o` at 0. A read with no strobe clears it. In all other cycles it holds.
- R7: `aux_ovw_o` is never set while `aux_new_o` is clear.
- R8: A `cfg_chg_i` pulse is remembered until the next `blk16_stb_i`, which raises `cfg_flag_o`. A pulse in the same cycle as the boundary strobe also counts. `cfg_flag_o` stays set until a `rd_status_i` read clears it. A raise in the same cycle as the read wins.
- R9: While `rst_ni` is low, every output is 0.
- R10: `rd_status_i` has no effect on the auxiliary flags, and `rd_aux1_i` has no effect on `cfg_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe per decoded frame |
| err_flag_i | input | 1 | One-cycle pulse per decoder error flag |
| blk16_stb_i | input | 1 | One-cycle strobe at each 16-frame boundary |
| cfg_chg_i | input | 1 | One-cycle pulse when the transmission configuration changes |
| aux_bits_i | input | 11 | Auxiliary data bits of the current frame |
| rd_status_i | input | 1 | Host read strobe of the status byte |
| rd_aux1_i | input | 1 | Host read strobe of the upper auxiliary byte |
| err_cnt_o | output | 8 | Error tally of the last closed window |
| cfg_flag_o | output | 1 | Configuration-change flag |
| aux_hi_o | output | 8 | Auxiliary bits 10..3 |
| aux_lo_o | output | 3 | Auxiliary bits 2..0 |
| aux_new_o | output | 1 | Unread auxiliary word pending |
| aux_ovw_o | output | 1 | Unread auxiliary word was replaced |

## Verification
The assertions assume that every strobe and pulse lasts one clock and that `aux_bits_i` is valid in the cycle of its frame strobe. They also assume the host read strobes are single-cycle. They put no limit on how the events coincide, so the boundary strobe, configuration pulse, frame strobe and both reads may all fall in the same cycle.

The stimulus drives every input at the falling edge and holds it for one full cycle. It mixes sparse random traffic with a phase of one error every cycle, which drives the tally into saturation, and a phase with no errors. It also places frame strobes on the same cycle as `rd_aux1_i`, and raises on the same cycle as `rd_status_i`, so that each priority rule is exercised.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned AUX_W      = 11;
  localparam int unsigned AUX_HI_W   = 8;
  localparam int unsigned CNT_W      = 8;
  localparam int unsigned WIN_FRAMES = 128;

  typedef struct packed {
    logic fresh;
    logic lost;
  } aux_flags_t;
endpackage

// File: rtl/dsr_err_window.sv
module dsr_err_window #(
  parameter int unsigned CNT_W      = dsr_pkg::CNT_W,
  parameter int unsigned WIN_FRAMES = dsr_pkg::WIN_FRAMES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_stb_i,
  input  logic             err_flag_i,
  output logic [CNT_W-1:0] err_cnt_o
);
  localparam int unsigned WIN_W = (WIN_FRAMES > 1) ? $clog2(WIN_FRAMES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_FRAMES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_inc;
  logic             win_close;

  always_comb begin
    acc_inc = acc_q;
    if (err_flag_i && acc_q != CNT_MAX) acc_inc = acc_q + 1'b1;
  end

  assign win_close = frame_stb_i && (win_q == WIN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= '0;
      acc_q     <= '0;
      err_cnt_o <= '0;
    end else if (win_close) begin
      err_cnt_o <= acc_inc;
      acc_q     <= '0;
      win_q     <= '0;
    end else begin
      acc_q <= acc_inc;
      if (frame_stb_i) win_q <= win_q + 1'b1;
    end
  end
endmodule

// File: rtl/dsr_aux_latch.sv
module dsr_aux_latch #(
  parameter int unsigned AUX_W    = dsr_pkg::AUX_W,
  parameter int unsigned AUX_HI_W = dsr_pkg::AUX_HI_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_stb_i,
  input  logic [AUX_W-1:0]          aux_bits_i,
  input  logic                      rd_aux1_i,
  output logic [AUX_HI_W-1:0]       aux_hi_o,
  output logic [AUX_W-AUX_HI_W-1:0] aux_lo_o,
  output dsr_pkg::aux_flags_t       flags_o
);
  localparam int unsigned LO_W = AUX_W - AUX_HI_W;

  logic [AUX_W-1:0]    word_q;
  dsr_pkg::aux_flags_t flg_q, flg_d;

  always_comb begin
    flg_d = flg_q;
    if (frame_stb_i) begin
      // a same-cycle read consumes the word being replaced
      flg_d.lost  = (flg_q.fresh | flg_q.lost) & ~rd_aux1_i;
      flg_d.fresh = 1'b1;
    end else if (rd_aux1_i) begin
      flg_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      flg_q  <= '0;
    end else begin
      flg_q <= flg_d;
      if (frame_stb_i) word_q <= aux_bits_i;
    end
  end

  assign aux_hi_o = word_q[AUX_W-1:LO_W];
  assign aux_lo_o = word_q[LO_W-1:0];
  assign flags_o  = flg_q;
endmodule

// File: rtl/dsr_cfg_flag.sv
module dsr_cfg_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk16_stb_i,
  input  logic cfg_chg_i,
  input  logic rd_status_i,
  output logic cfg_flag_o
);
  logic pend_q;
  logic raise;

  assign raise = blk16_stb_i && (pend_q || cfg_chg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      cfg_flag_o <= 1'b0;
    end else begin
      if (blk16_stb_i)    pend_q <= 1'b0;
      else if (cfg_chg_i) pend_q <= 1'b1;
      if (raise)            cfg_flag_o <= 1'b1;
      else if (rd_status_i) cfg_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dec_status_regs.sv
module dec_status_regs #(
  parameter int unsigned AUX_W      = dsr_pkg::AUX_W,
  parameter int unsigned AUX_HI_W   = dsr_pkg::AUX_HI_W,
  parameter int unsigned CNT_W      = dsr_pkg::CNT_W,
  parameter int unsigned WIN_FRAMES = dsr_pkg::WIN_FRAMES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      frame_stb_i,
  input  logic                      err_flag_i,
  input  logic                      blk16_stb_i,
  input  logic                      cfg_chg_i,
  input  logic [AUX_W-1:0]          aux_bits_i,
  input  logic                      rd_status_i,
  input  logic                      rd_aux1_i,
  output logic [CNT_W-1:0]          err_cnt_o,
  output logic                      cfg_flag_o,
  output logic [AUX_HI_W-1:0]       aux_hi_o,
  output logic [AUX_W-AUX_HI_W-1:0] aux_lo_o,
  output logic                      aux_new_o,
  output logic                      aux_ovw_o
);
  dsr_pkg::aux_flags_t aux_flags;

  dsr_err_window #(.CNT_W(CNT_W), .WIN_FRAMES(WIN_FRAMES)) u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_stb_i (frame_stb_i),
    .err_flag_i  (err_flag_i),
    .err_cnt_o   (err_cnt_o)
  );

  dsr_aux_latch #(.AUX_W(AUX_W), .AUX_HI_W(AUX_HI_W)) u_aux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_stb_i (frame_stb_i),
    .aux_bits_i  (aux_bits_i),
    .rd_aux1_i   (rd_aux1_i),
    .aux_hi_o    (aux_hi_o),
    .aux_lo_o    (aux_lo_o),
    .flags_o     (aux_flags)
  );

  dsr_cfg_flag u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blk16_stb_i (blk16_stb_i),
    .cfg_chg_i   (cfg_chg_i),
    .rd_status_i (rd_status_i),
    .cfg_flag_o  (cfg_flag_o)
  );

  assign aux_new_o = aux_flags.fresh;
  assign aux_ovw_o = aux_flags.lost;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker #(
  parameter int unsigned AUX_W    = dsr_pkg::AUX_W,
  parameter int unsigned AUX_HI_W = dsr_pkg::AUX_HI_W,
  parameter int unsigned CNT_W    = dsr_pkg::CNT_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      frame_stb_i,
  input logic                      blk16_stb_i,
  input logic                      cfg_chg_i,
  input logic [AUX_W-1:0]          aux_bits_i,
  input logic                      rd_status_i,
  input logic                      rd_aux1_i,
  input logic [CNT_W-1:0]          err_cnt_o,
  input logic                      cfg_flag_o,
  input logic [AUX_HI_W-1:0]       aux_hi_o,
  input logic [AUX_W-AUX_HI_W-1:0] aux_lo_o,
  input logic                      aux_new_o,
  input logic                      aux_ovw_o
);
  a_r2_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> $stable(err_cnt_o));

  a_r4_aux_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i |=> ({aux_hi_o, aux_lo_o} == $past(aux_bits_i)));

  a_r4_aux_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_stb_i |=> $stable({aux_hi_o, aux_lo_o}));

  a_r5_new_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_stb_i |=> aux_new_o);

  a_r5_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_aux1_i && !frame_stb_i) |=> (!aux_new_o && !aux_ovw_o));

  a_r6_ovw_on_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_stb_i && aux_new_o && !rd_aux1_i) |=> aux_ovw_o);

  a_r7_ovw_needs_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_ovw_o |-> aux_new_o);

  a_r8_cfg_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk16_stb_i && cfg_chg_i) |=> cfg_flag_o);

  a_r8_cfg_rise_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_flag_o) |-> $past(blk16_stb_i));

  a_r8_cfg_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status_i && !blk16_stb_i) |=> !cfg_flag_o);

  a_r10_aux_read_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_aux1_i && !rd_status_i && !blk16_stb_i) |=> $stable(cfg_flag_o));
endmodule

bind dec_status_regs dsr_checker #(
  .AUX_W(AUX_W), .AUX_HI_W(AUX_HI_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_stb_i (frame_stb_i),
  .blk16_stb_i (blk16_stb_i),
  .cfg_chg_i   (cfg_chg_i),
  .aux_bits_i  (aux_bits_i),
  .rd_status_i (rd_status_i),
  .rd_aux1_i   (rd_aux1_i),
  .err_cnt_o   (err_cnt_o),
  .cfg_flag_o  (cfg_flag_o),
  .aux_hi_o    (aux_hi_o),
  .aux_lo_o    (aux_lo_o),
  .aux_new_o   (aux_new_o),
  .aux_ovw_o   (aux_ovw_o)
);

// File: tb/sim_dec_status_regs.sv
module sim_dec_status_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0, err = 1'b0, blk = 1'b0, cfg = 1'b0;
  logic        rds = 1'b0, rda = 1'b0;
  logic [10:0] aux = '0;
  logic [7:0]  err_cnt_o, aux_hi_o;
  logic [2:0]  aux_lo_o;
  logic        cfg_flag_o, aux_new_o, aux_ovw_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_win, m_acc, m_err, m_aux;
  bit m_new, m_ovw, m_pend, m_cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_status_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_stb_i(frame), .err_flag_i(err),
    .blk16_stb_i(blk), .cfg_chg_i(cfg), .aux_bits_i(aux),
    .rd_status_i(rds), .rd_aux1_i(rda), .err_cnt_o(err_cnt_o),
    .cfg_flag_o(cfg_flag_o), .aux_hi_o(aux_hi_o), .aux_lo_o(aux_lo_o),
    .aux_new_o(aux_new_o), .aux_ovw_o(aux_ovw_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_win = 0; m_acc = 0; m_err = 0; m_aux = 0;
      m_new = 0; m_ovw = 0; m_pend = 0; m_cfg = 0;
    end else begin
      bit raise;
      if (err) m_acc = (m_acc < 255) ? m_acc + 1 : 255;
      if (frame) begin
        if (m_win == 127) begin m_err = m_acc; m_acc = 0; m_win = 0; end
        else m_win++;
      end
      if (frame) begin
        m_ovw = (m_ovw || m_new) && !rda;
        m_new = 1;
        m_aux = int'(aux);
      end else if (rda) begin
        m_new = 0; m_ovw = 0;
      end
      raise = 0;
      if (blk) begin raise = m_pend || cfg; m_pend = 0; end
      else if (cfg) m_pend = 1;
      if (raise) m_cfg = 1;
      else if (rds) m_cfg = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(err_cnt_o) == m_err, "R1/R2/R3 err_cnt", int'(err_cnt_o), m_err);
      chk(int'({aux_hi_o, aux_lo_o}) == m_aux, "R4 aux word", int'({aux_hi_o, aux_lo_o}), m_aux);
      chk(aux_new_o == m_new, "R5/R10 aux_new", int'(aux_new_o), int'(m_new));
      chk(aux_ovw_o == m_ovw, "R6/R7 aux_ovw", int'(aux_ovw_o), int'(m_ovw));
      chk(cfg_flag_o == m_cfg, "R8/R10 cfg_flag", int'(cfg_flag_o), int'(m_cfg));
    end
  end

  task automatic cyc(input bit f, input bit e, input bit b, input bit c,
                     input logic [10:0] a, input bit s, input bit r);
    @(negedge clk);
    frame = f; err = e; blk = b; cfg = c; aux = a; rds = s; rda = r;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 11'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk({err_cnt_o, cfg_flag_o, aux_hi_o, aux_lo_o, aux_new_o, aux_ovw_o} == '0,
        "R9 reset outputs", int'(err_cnt_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // sparse random traffic
    for (int i = 0; i < 1600; i++)
      cyc(i % 4 == 3, $urandom_range(7) == 0, i % 64 == 63, $urandom_range(49) == 0,
          11'($urandom), $urandom_range(9) == 0, $urandom_range(5) == 0);

    // R3: error every cycle, two full windows
    for (int i = 0; i < 1100; i++)
      cyc(i % 4 == 3, 1, 0, 0, 11'($urandom), 0, i % 8 == 0);
    idle();
    @(negedge clk);
    chk(err_cnt_o == 8'd255, "R3 saturated tally", int'(err_cnt_o), 255);

    // R1/R2: quiet windows bring the tally to zero
    for (int i = 0; i < 1100; i++)
      cyc(i % 4 == 3, 0, 0, 0, 11'h0, 0, 0);
    idle();
    @(negedge clk);
    chk(err_cnt_o == 8'd0, "R1 error-free window", int'(err_cnt_o), 0);

    // R4/R5/R6: directed aux flags
    cyc(0, 0, 0, 0, 11'h0, 0, 1);
    cyc(1, 0, 0, 0, 11'h5A3, 0, 0);
    idle();
    chk({aux_hi_o, aux_lo_o} == 11'h5A3 && aux_hi_o == 8'hB4 && aux_lo_o == 3'd3,
        "R4 byte split", int'({aux_hi_o, aux_lo_o}), 'h5A3);
    chk(aux_new_o && !aux_ovw_o, "R5 new after latch", int'(aux_new_o), 1);
    cyc(1, 0, 0, 0, 11'h123, 0, 0);
    idle();
    chk(aux_ovw_o == 1'b1, "R6 overrun sets ovw", int'(aux_ovw_o), 1);
    cyc(1, 0, 0, 0, 11'h7FF, 0, 1);
    idle();
    chk(aux_new_o && !aux_ovw_o, "R5 latch wins over read", int'({aux_new_o, aux_ovw_o}), 2);
    cyc(0, 0, 0, 0, 11'h0, 1, 0);
    idle();
    chk(aux_new_o == 1'b1, "R10 status read keeps aux_new", int'(aux_new_o), 1);
    cyc(0, 0, 0, 0, 11'h0, 0, 1);
    idle();
    chk(!aux_new_o && !aux_ovw_o, "R5 read clears", int'({aux_new_o, aux_ovw_o}), 0);

    // R8/R10: directed config flag
    cyc(0, 0, 0, 1, 11'h0, 0, 0);
    idle();
    chk(cfg_flag_o == 1'b0, "R8 waits for boundary", int'(cfg_flag_o), 0);
    cyc(0, 0, 1, 0, 11'h0, 0, 0);
    idle();
    chk(cfg_flag_o == 1'b1, "R8 raised at boundary", int'(cfg_flag_o), 1);
    cyc(0, 0, 0, 0, 11'h0, 0, 1);
    idle();
    chk(cfg_flag_o == 1'b1, "R10 aux read keeps cfg", int'(cfg_flag_o), 1);
    cyc(0, 0, 1, 1, 11'h0, 1, 0);
    idle();
    chk(cfg_flag_o == 1'b1, "R8 raise wins over read", int'(cfg_flag_o), 1);
    cyc(0, 0, 0, 0, 11'h0, 1, 0);
    idle();
    chk(cfg_flag_o == 1'b0, "R8 read clears", int'(cfg_flag_o), 0);

    repeat (4) idle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule